// File: doc/BRIEF.md
# Power-Management Sleep Control Register

This block holds one 16-bit sleep-control word inside a 16-byte power-management I/O window. A host reaches it over a plain I/O bus: a byte address, one byte-enable per lane, write data, and separate write and read strobes. A word access writes or reads both lanes at once. A byte access touches only its own lane, and the other lane keeps its stored contents.

Two bits of the word are command bits: the lock-release bit (bit 2) and the sleep-enable bit (bit 13). The register stores them, but a read always returns them as zero. A write is a power-off command when it touches the upper lane, sets sleep-enable, and places the all-ones code in the three-bit sleep-type field at bits 12:10. Such a write produces a single-cycle shutdown request for the platform's power sequencer. All other window offsets read as zero, and writes to them have no effect.

Top module: `pm1_ctl_top`

## Requirements
- R1: During and after synchronous reset, the stored word is 0x0001: only bit 0, the interrupt-routing enable, is set.
- R2: The word answers at byte address BASE+4, which is 0x1F44 by default. Address bit 0 is ignored. io_be[0] selects bits 7:0 (offset 4) and io_be[1] selects bits 15:8 (offset 5). A write with io_be=2'b11 replaces all 16 bits at the next rising clock edge.
- R3: A write with io_be=2'b01 replaces bits 7:0 and leaves bits 15:8 unchanged.
- R4: A write with io_be=2'b10 replaces bits 15:8 and leaves bits 7:0 unchanged.
- R5: A read returns the stored word in the same cycle as io_rd, with bits 2 and 13 forced to 0. A byte lane whose enable is low reads as 0.
- R6: A write with io_be[1]=1, wdata[13]=1 and wdata[12:10]=3'b111 drives shutdown_req high for exactly the one cycle that follows the write edge.
- R7: No shutdown pulse occurs when the written sleep-type field is not 3'b111, or when the written bit 13 is 0.
- R8: A write with io_be=2'b01 never produces a shutdown pulse, even when the stored bits 13:10 already hold 4'b1111.
- R9: Any other address, whether elsewhere in the window or outside it, reads as 0 and is ignored on write.
- R10: io_rdata is 0 in every cycle where io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Byte address of the access |
| io_be | input | 2 | Byte-lane enables (bit 0 = low lane) |
| io_wdata | input | 16 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 16 | Combinational read data |
| shutdown_req | output | 1 | Registered one-cycle power-off request |

## Verification
The bench builds the block with its default parameters: a 16-bit word of two lanes, base 0x1F40, control offset 4, reset value 0x0001, and write-only mask 0x2004. With these values every lane combination can be driven against the real sleep-field position. The bench places writes on both sides of the soft-off code and probes the neighbouring offsets 0x1F40, 0x1F46 and 0x1F4E. It also repeats command bits already held in storage through a low-lane write, to confirm that such a write raises no request.

// File: rtl/pm1_pkg.sv
package pm1_pkg;
  localparam int LANE_W = 8;

  function automatic int lanes_of(input int data_w);
    return data_w / LANE_W;
  endfunction
endpackage

// File: rtl/pm1_decode.sv
module pm1_decode #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2,
  parameter logic [ADDR_W-1:0] BASE   = 16'h1F40,
  parameter logic [ADDR_W-1:0] OFFSET = 16'h0004
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int SUB_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [ADDR_W-1:0] TARGET   = BASE + OFFSET;
  localparam logic [ADDR_W-1:0] SUB_MASK = ADDR_W'((1 << SUB_W) - 1);

  always_comb hit = (((addr ^ TARGET) & ~SUB_MASK) == '0);
endmodule

// File: rtl/pm1_ctl_reg.sv
module pm1_ctl_reg
  import pm1_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] RST_VAL = 16'h0001,
  parameter logic [DATA_W-1:0] WO_MASK = 16'h2004
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [lanes_of(DATA_W)-1:0]   be,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata
);
  localparam int LANES = lanes_of(DATA_W);

  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] ctl_nxt;
  logic [DATA_W-1:0] visible;

  assign visible = ctl_q & ~WO_MASK;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign ctl_nxt[i*LANE_W +: LANE_W] =
      (wr_en && be[i]) ? wdata[i*LANE_W +: LANE_W] : ctl_q[i*LANE_W +: LANE_W];
    assign rdata[i*LANE_W +: LANE_W] =
      (rd_en && be[i]) ? visible[i*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= RST_VAL;
    else     ctl_q <= ctl_nxt;
  end

  p_low_keeps_high_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && be == 2'b01) |=> ctl_q[15:8] == $past(ctl_q[15:8]));

  p_high_keeps_low_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && be == 2'b10) |=> ctl_q[7:0] == $past(ctl_q[7:0]));

  p_word_readback_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && be == 2'b11) && rd_en && be == 2'b11)
      |-> rdata == ($past(wdata) & ~WO_MASK));
endmodule

// File: rtl/pm1_sleep_det.sv
module pm1_sleep_det #(
  parameter int TYP_W = 3,
  parameter logic [TYP_W-1:0] SOFF_CODE = 3'b111
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           lane_touch,
  input  logic [TYP_W:0] cmd_bits,
  output logic           pulse
);
  logic fire;

  always_comb fire = wr_en && lane_touch && cmd_bits[TYP_W]
                     && (cmd_bits[TYP_W-1:0] == SOFF_CODE);

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= fire;
  end

  p_pulse_source_r6: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(wr_en && lane_touch));

  p_wrong_type_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cmd_bits[TYP_W-1:0] != SOFF_CODE) |=> !pulse);

  p_low_only_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !lane_touch) |=> !pulse);
endmodule

// File: rtl/pm1_ctl_top.sv
module pm1_ctl_top
  import pm1_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'h1F40,
  parameter logic [ADDR_W-1:0] OFFSET = 16'h0004,
  parameter logic [DATA_W-1:0] RST_VAL = 16'h0001,
  parameter logic [DATA_W-1:0] WO_MASK = 16'h2004,
  parameter int SLP_EN_BIT = 13,
  parameter int TYP_LSB    = 10,
  parameter int TYP_W      = 3,
  parameter logic [TYP_W-1:0] SOFF_CODE = 3'b111
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           io_addr,
  input  logic [DATA_W/8-1:0]         io_be,
  input  logic [DATA_W-1:0]           io_wdata,
  input  logic                        io_wr,
  input  logic                        io_rd,
  output logic [DATA_W-1:0]           io_rdata,
  output logic                        shutdown_req
);
  localparam int LANES    = lanes_of(DATA_W);
  localparam int CMD_LANE = SLP_EN_BIT / LANE_W;

  logic hit;
  logic wr_hit;
  logic rd_hit;
  logic [DATA_W-1:0] reg_rdata;

  pm1_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BASE(BASE), .OFFSET(OFFSET)
  ) u_decode (
    .addr(io_addr), .hit(hit)
  );

  assign wr_hit = io_wr && hit;
  assign rd_hit = io_rd && hit;

  pm1_ctl_reg #(
    .DATA_W(DATA_W), .RST_VAL(RST_VAL), .WO_MASK(WO_MASK)
  ) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_hit), .rd_en(rd_hit),
    .be(io_be), .wdata(io_wdata), .rdata(reg_rdata)
  );

  pm1_sleep_det #(
    .TYP_W(TYP_W), .SOFF_CODE(SOFF_CODE)
  ) u_sleep (
    .clk(clk), .rst(rst), .wr_en(wr_hit), .lane_touch(io_be[CMD_LANE]),
    .cmd_bits(io_wdata[SLP_EN_BIT:TYP_LSB]), .pulse(shutdown_req)
  );

  assign io_rdata = rd_hit ? reg_rdata : '0;

  p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !hit) |-> io_rdata == '0);

  p_idle_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !io_rd |-> io_rdata == '0);

  p_miss_no_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !hit) |=> !shutdown_req);
endmodule

// File: tb/test_pm1_ctl_top.sv
module test_pm1_ctl_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_be = '0;
  logic [15:0] io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [15:0] io_rdata;
  logic        shutdown_req;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  logic [15:0] ref_ctl = 16'h0001;
  logic        ref_sd = 1'b0;

  always #5 clk = ~clk;

  pm1_ctl_top i_pm1_ctl_top (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_be(io_be),
    .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .shutdown_req(shutdown_req)
  );

  function automatic bit is_ctl(input logic [15:0] a);
    return (a & 16'hFFFE) == 16'h1F44;
  endfunction

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      ref_ctl = 16'h0001;
      ref_sd  = 1'b0;
    end else begin
      ref_sd = io_wr && is_ctl(io_addr) && io_be[1] && io_wdata[13]
               && (io_wdata[12:10] == 3'b111);
      if (io_wr && is_ctl(io_addr)) begin
        if (io_be[0]) ref_ctl[7:0]  = io_wdata[7:0];
        if (io_be[1]) ref_ctl[15:8] = io_wdata[15:8];
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison, mid-cycle
  always @(negedge clk) begin
    logic [15:0] exp_rd;
    exp_rd = '0;
    if (io_rd && is_ctl(io_addr)) begin
      if (io_be[0]) exp_rd[7:0]  = ref_ctl[7:0]  & 8'hFB;
      if (io_be[1]) exp_rd[15:8] = ref_ctl[15:8] & 8'hDF;
    end
    check(cur_req, "rdata", io_rdata, exp_rd);
    check(cur_req, "shutdown_req", {15'd0, shutdown_req}, {15'd0, ref_sd});
  end

  task automatic acc(input logic [15:0] a, input logic [1:0] be,
                     input logic [15:0] d, input logic wr, input logic rd,
                     input string req);
    @(posedge clk);
    #1;
    cur_req = req;
    io_addr = a; io_be = be; io_wdata = d; io_wr = wr; io_rd = rd;
  endtask

  task automatic wr_(input logic [15:0] a, input logic [1:0] be,
                     input logic [15:0] d, input string req);
    acc(a, be, d, 1'b1, 1'b0, req);
  endtask

  task automatic rd_(input logic [15:0] a, input logic [1:0] be, input string req);
    acc(a, be, 16'h0, 1'b0, 1'b1, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset value read during and after reset
    acc(16'h1F44, 2'b11, 16'h0, 1'b0, 1'b1, "R1");
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    rd_(16'h1F44, 2'b11, "R1");
    #4 check("R1", "direct reset read", io_rdata, 16'h0001);
    // R2: full word write, also via odd address
    wr_(16'h1F44, 2'b11, 16'h0403, "R2");
    rd_(16'h1F45, 2'b11, "R2");
    #4 check("R2", "word readback", io_rdata, 16'h0403);
    // R3: low lane write
    wr_(16'h1F44, 2'b01, 16'hFFA5, "R3");
    rd_(16'h1F44, 2'b11, "R3");
    #4 check("R3", "low merge", io_rdata, 16'h04A1);
    // R4: high lane write
    wr_(16'h1F45, 2'b10, 16'h5A11, "R4");
    rd_(16'h1F44, 2'b11, "R4");
    #4 check("R4", "high merge", io_rdata, 16'h5AA1);
    // R5: masking of bits 2 and 13, lane-gated reads
    wr_(16'h1F44, 2'b11, 16'hE7FF, "R5");
    rd_(16'h1F44, 2'b11, "R5");
    #4 check("R5", "masked word", io_rdata, 16'hC7FB);
    rd_(16'h1F44, 2'b01, "R5");
    #4 check("R5", "low byte read", io_rdata, 16'h00FB);
    rd_(16'h1F45, 2'b10, "R5");
    #4 check("R5", "high byte read", io_rdata, 16'hC700);
    // R6: word power-off write, then high-lane power-off write
    wr_(16'h1F44, 2'b11, 16'h3C01, "R6");
    acc(16'h1F44, 2'b00, 16'h0, 1'b0, 1'b0, "R6");
    #4 check("R6", "pulse after word write", {15'd0, shutdown_req}, 16'h0001);
    acc(16'h1F44, 2'b00, 16'h0, 1'b0, 1'b0, "R6");
    #4 check("R6", "pulse one cycle", {15'd0, shutdown_req}, 16'h0000);
    wr_(16'h1F45, 2'b10, 16'h3C00, "R6");
    acc(16'h1F44, 2'b00, 16'h0, 1'b0, 1'b0, "R6");
    #4 check("R6", "pulse after high write", {15'd0, shutdown_req}, 16'h0001);
    // R7: wrong sleep type, or sleep-enable clear
    wr_(16'h1F44, 2'b11, 16'h3801, "R7");
    acc(16'h1F44, 2'b00, 16'h0, 1'b0, 1'b0, "R7");
    #4 check("R7", "type 110 quiet", {15'd0, shutdown_req}, 16'h0000);
    wr_(16'h1F45, 2'b10, 16'h1C00, "R7");
    acc(16'h1F44, 2'b00, 16'h0, 1'b0, 1'b0, "R7");
    #4 check("R7", "enable clear quiet", {15'd0, shutdown_req}, 16'h0000);
    // R8: stored bits 13:10 all set, then low-only write
    wr_(16'h1F44, 2'b11, 16'h3C00, "R8");
    wr_(16'h1F44, 2'b01, 16'hFF33, "R8");
    acc(16'h1F44, 2'b00, 16'h0, 1'b0, 1'b0, "R8");
    #4 check("R8", "low write quiet", {15'd0, shutdown_req}, 16'h0000);
    // R9: other offsets and addresses
    wr_(16'h1F40, 2'b11, 16'hFFFF, "R9");
    wr_(16'h1F46, 2'b11, 16'hFFFF, "R9");
    wr_(16'h1F4E, 2'b11, 16'hFFFF, "R9");
    wr_(16'h2044, 2'b11, 16'hFFFF, "R9");
    rd_(16'h1F46, 2'b11, "R9");
    #4 check("R9", "miss read", io_rdata, 16'h0000);
    rd_(16'h1F44, 2'b11, "R9");
    #4 check("R9", "word unchanged", io_rdata, 16'h1C33);
    // R10: idle read data
    acc(16'h1F44, 2'b11, 16'h0, 1'b0, 1'b0, "R10");
    #4 check("R10", "idle rdata", io_rdata, 16'h0000);
    acc(16'h1F44, 2'b11, 16'h0, 1'b0, 1'b0, "R10");
    repeat (2) @(posedge clk);
    #6;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule